// File: doc/BRIEF.md
# Gated 8-bit Auto-Reload Timer

This block is a small counter/timer for a larger chip. A live 8-bit count steps up by one for each increment event. When the count steps past all ones, the block does two things. It loads the count again from a separate reload register, and it sets a sticky overflow flag. The reload register keeps whatever software last wrote to it, so the block repeats the same period without further software work. The flag can drive an interrupt request when the interrupt enable is set.

Increment events come from one of two places. The first is the internal path: every system clock, or only the cycles on which a prescaled tick input is high. The second is falling edges on an external count pin, which passes through a synchronizer first. Counting is allowed only while the run bit is set. When gating is on, the external gate input must also be at the level chosen by a polarity bit. All settings arrive through a single-cycle register write port with a 2-bit address.

Top module: `reload_timer8`

## Requirements
- R1: After reset, the count, the reload register, the overflow flag, the control bits and the interrupt are all 0, and the count does not move while no write arrives.
- R2: With the internal source selected, prescaler off and the timer enabled, the count rises by one on every clock edge. A write takes effect at the edge where it is presented.
- R3: With control bit 4 set (prescaled internal source), the count advances only on edges where `tick_in` is high.
- R4: A step taken from 0xFF loads the count from the reload register and sets the overflow flag on the same edge.
- R5: An automatic reload leaves the reload register unchanged. Only a write to address 1 alters it.
- R6: `irq_o` is high exactly when the overflow flag is set and control bit 5 (interrupt enable) is 1.
- R7: With control bit 0 (run) at 0, the count holds its value whatever the other inputs do.
- R8: With control bit 1 (gate) set, counting also needs `gate_in ^ pol` to be 1, where pol is control bit 2. So pol=0 makes the gate active-high and pol=1 makes it active-low. With gate at 0, `gate_in` has no effect.
- R9: With control bit 3 set (external source), each falling edge of `cnt_pin` adds one, three clock edges after the pin changes. Rising edges and the internal clock path add nothing.
- R10: The overflow flag stays set until a write to address 3 with data bit 0 high. A write with bit 0 low leaves it set. If an overflow and a clear fall on the same edge, the flag ends up set.
- R11: A write to the count on the same edge as an overflow stores the written value instead of the reload value. The flag is still set.
- R12: Address map: 0 is the count, 1 is the reload value, 2 is control (bit0 run, bit1 gate, bit2 pol, bit3 external source, bit4 prescaled, bit5 interrupt enable), and 3 is the flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register address |
| wr_data | input | W | Write data |
| gate_in | input | 1 | External gate level, synchronous to clk |
| tick_in | input | 1 | Prescaled clock enable |
| cnt_pin | input | 1 | External count pin, asynchronous |
| count_o | output | W | Live count |
| reload_o | output | W | Reload register value |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write, an internal step and an overflow each show at the ports one clock edge after they are presented. The interrupt follows the flag and the enable with no extra delay. A falling edge on the count pin needs three edges: two synchronizer flops and one edge-detect stage.

The bench drives every input just after a falling clock edge. It counts the rising edges during which the timer was enabled, and it samples at the next falling edge. For the pin path, it checks that the count has not moved after two edges and has moved after the third.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_COUNT   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL    = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAGCLR = 2'd3;

  // control word, run bit at bit 0
  typedef struct packed {
    logic irq_en;
    logic pre_sel;
    logic ext_src;
    logic pol;
    logic gate;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] d);
    return ctrl_t'(d);
  endfunction

  // gate passes when gating is off or the input sits at its active level
  function automatic logic gate_open(input logic gate, input logic lvl, input logic pol);
    return !gate || (lvl ^ pol);
  endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall_o
);
  localparam int unsigned SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;

  genvar g;
  generate
    for (g = 0; g < SH_W; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sh_q[g] <= 1'b1;
        else if (g == 0) sh_q[g] <= pin;
        else             sh_q[g] <= sh_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  // last synchronized sample low, previous sample high
  assign fall_o = sh_q[SH_W-1] & ~sh_q[SH_W-2];
endmodule

// File: rtl/tmr_step_sel.sv
module tmr_step_sel
  import tmr_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  gate_in,
  input  logic  tick_in,
  input  logic  pin_fall,
  output logic  run_en,
  output logic  step_o
);
  logic int_evt;

  assign run_en  = ctrl.run && gate_open(ctrl.gate, gate_in, ctrl.pol);
  assign int_evt = ctrl.pre_sel ? tick_in : 1'b1;
  assign step_o  = run_en && (ctrl.ext_src ? pin_fall : int_evt);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_wr,
  input  logic         reload_wr,
  input  logic         flag_clr,
  input  logic [W-1:0] wr_data,
  input  logic         step,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reload_o,
  output logic         flag_o,
  output logic         ovf_evt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, rld_q;
  logic         flag_q;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c, input logic [W-1:0] r);
    return (c == CNT_MAX) ? r : c + 1'b1;
  endfunction

  assign ovf_evt = step && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (reload_wr) rld_q <= wr_data;
      if (cnt_wr)    cnt_q <= wr_data;
      else if (step) cnt_q <= next_count(cnt_q, rld_q);
      if (ovf_evt)       flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = rld_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/reload_timer8.sv
module reload_timer8
  import tmr_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              gate_in,
  input  logic              tick_in,
  input  logic              cnt_pin,
  output logic [W-1:0]      count_o,
  output logic [W-1:0]      reload_o,
  output logic              ovf_o,
  output logic              irq_o
);
  ctrl_t ctrl_q;
  logic  cnt_wr, reload_wr, ctrl_wr, flag_clr;
  logic  pin_fall, run_en, step, ovf_evt;

  assign cnt_wr    = wr_en && (wr_addr == A_COUNT);
  assign reload_wr = wr_en && (wr_addr == A_RELOAD);
  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign flag_clr  = wr_en && (wr_addr == A_FLAGCLR) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= decode_ctrl(wr_data[CTRL_W-1:0]);
  end

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall_o(pin_fall)
  );

  tmr_step_sel sel_i (
    .ctrl(ctrl_q), .gate_in(gate_in), .tick_in(tick_in),
    .pin_fall(pin_fall), .run_en(run_en), .step_o(step)
  );

  tmr_count_core #(.W(W)) core_i (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .reload_wr(reload_wr),
    .flag_clr(flag_clr), .wr_data(wr_data), .step(step),
    .count_o(count_o), .reload_o(reload_o), .flag_o(ovf_o), .ovf_evt(ovf_evt)
  );

  assign irq_o = ovf_o && ctrl_q.irq_en;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_wr,
  input logic         reload_wr,
  input logic         flag_clr,
  input logic [W-1:0] wr_data,
  input logic         run_en,
  input logic         step,
  input logic         ovf_evt,
  input logic [W-1:0] count_o,
  input logic [W-1:0] reload_o,
  input logic         ovf_o,
  input logic         irq_o
);
  localparam logic [W-1:0] TOP = '1;

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr && count_o != TOP) |=> count_o == $past(count_o) + 1'b1);

  // R4
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !cnt_wr) |=> count_o == $past(reload_o));

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_o);

  // R5
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_wr |=> $stable(reload_o));

  // R6
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ovf_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> $stable(count_o));

  // R7
  step_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> run_en);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !flag_clr) |=> ovf_o);

  // R11
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_o == $past(wr_data));
endmodule

bind reload_timer8 tmr_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .reload_wr(reload_wr),
  .flag_clr(flag_clr), .wr_data(wr_data), .run_en(run_en), .step(step),
  .ovf_evt(ovf_evt), .count_o(count_o), .reload_o(reload_o),
  .ovf_o(ovf_o), .irq_o(irq_o)
);

// File: tb/reload_timer8_tb_top.sv
`timescale 1ns/1ps
module reload_timer8_tb_top;
  localparam int NV = 7;
  localparam logic [7:0] V_RLD [NV] = '{8'h00, 8'h10, 8'h10, 8'hF0, 8'hFF, 8'h00, 8'h80};
  localparam logic [7:0] V_ST  [NV] = '{8'h00, 8'hFD, 8'hFD, 8'hF0, 8'hFF, 8'hFF, 8'h70};
  localparam int         V_N   [NV] = '{5, 3, 5, 20, 3, 1, 16};
  localparam logic [7:0] V_EXP [NV] = '{8'h05, 8'h10, 8'h12, 8'hF4, 8'hFF, 8'h00, 8'h80};
  localparam logic       V_FLG [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  localparam logic [1:0] A_COUNT = 2'd0, A_RELOAD = 2'd1, A_CTRL = 2'd2, A_FLAGCLR = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic gate_in = 1'b0, tick_in = 1'b0, cnt_pin = 1'b1;
  logic [7:0] count_o, reload_o;
  logic ovf_o, irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reload_timer8 dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gate_in(gate_in), .tick_in(tick_in), .cnt_pin(cnt_pin),
    .count_o(count_o), .reload_o(reload_o), .ovf_o(ovf_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // enables with control c for exactly n rising edges (n >= 1)
  task automatic run_for(input logic [7:0] c, input int n);
    wr(A_CTRL, c);
    repeat (n - 1) @(negedge clk);
    wr(A_CTRL, 8'h00);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and idle
    chk("R1 count", count_o, 8'h00);
    chk("R1 reload", reload_o, 8'h00);
    chk("R1 flag", ovf_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);
    repeat (5) @(negedge clk);
    chk("R1 idle count", count_o, 8'h00);

    // R2 R4 R5 R12: vector walk, internal source every clock
    for (int i = 0; i < NV; i++) begin
      wr(A_FLAGCLR, 8'h01);
      wr(A_RELOAD, V_RLD[i]);
      wr(A_COUNT, V_ST[i]);
      run_for(8'h01, V_N[i]);
      chk($sformatf("R2/R4 vec%0d count", i), count_o, V_EXP[i]);
      chk($sformatf("R4 vec%0d flag", i), ovf_o, V_FLG[i]);
      chk($sformatf("R5 vec%0d reload", i), reload_o, V_RLD[i]);
      chk($sformatf("R6 vec%0d irq off", i), irq_o, 1'b0);
    end

    // R7 run bit low: everything else on
    wr(A_COUNT, 8'h05);
    gate_in = 1'b1; tick_in = 1'b1;
    wr(A_CTRL, 8'h3E);
    repeat (10) @(negedge clk);
    chk("R7 no run count", count_o, 8'h05);
    wr(A_CTRL, 8'h00);
    gate_in = 1'b0;

    // R3 prescaled source: three tick cycles
    tick_in = 1'b0;
    wr(A_COUNT, 8'h20);
    wr(A_CTRL, 8'h11);
    repeat (4) @(negedge clk);
    chk("R3 no tick count", count_o, 8'h20);
    tick_in = 1'b1;
    repeat (3) @(negedge clk);
    tick_in = 1'b0;
    repeat (4) @(negedge clk);
    wr(A_CTRL, 8'h00);
    chk("R3 tick count", count_o, 8'h23);

    // R8 gate and polarity
    wr(A_COUNT, 8'h00);
    gate_in = 1'b0; run_for(8'h03, 6);
    chk("R8 pol0 closed", count_o, 8'h00);
    gate_in = 1'b1; run_for(8'h03, 6);
    chk("R8 pol0 open", count_o, 8'h06);
    gate_in = 1'b1; run_for(8'h07, 6);
    chk("R8 pol1 closed", count_o, 8'h06);
    gate_in = 1'b0; run_for(8'h07, 4);
    chk("R8 pol1 open", count_o, 8'h0A);
    gate_in = 1'b0; run_for(8'h05, 2);
    chk("R8 gate off ignores input", count_o, 8'h0C);

    // R9 external pin
    wr(A_COUNT, 8'h30);
    wr(A_CTRL, 8'h09);
    repeat (6) @(negedge clk);
    chk("R9 no clock steps", count_o, 8'h30);
    cnt_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 before latency", count_o, 8'h30);
    @(negedge clk);
    chk("R9 after fall", count_o, 8'h31);
    cnt_pin = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 rise ignored", count_o, 8'h31);
    cnt_pin = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 second fall", count_o, 8'h32);
    cnt_pin = 1'b1;
    wr(A_CTRL, 8'h00);
    repeat (4) @(negedge clk);

    // R6 R10 flag hold, clear and interrupt
    wr(A_FLAGCLR, 8'h01);
    wr(A_RELOAD, 8'h00);
    wr(A_COUNT, 8'hFF);
    run_for(8'h01, 1);
    chk("R10 flag set", ovf_o, 1'b1);
    repeat (10) @(negedge clk);
    chk("R10 flag held", ovf_o, 1'b1);
    wr(A_FLAGCLR, 8'h00);
    chk("R10 bit0 low no clear", ovf_o, 1'b1);
    chk("R6 irq disabled", irq_o, 1'b0);
    wr(A_CTRL, 8'h20);
    chk("R6 irq enabled", irq_o, 1'b1);
    wr(A_FLAGCLR, 8'h01);
    chk("R10 cleared", ovf_o, 1'b0);
    chk("R6 irq drops", irq_o, 1'b0);
    wr(A_CTRL, 8'h00);

    // R10 set beats clear on the same edge
    wr(A_COUNT, 8'hFF);
    wr(A_CTRL, 8'h01);
    wr(A_FLAGCLR, 8'h01);
    wr(A_CTRL, 8'h00);
    chk("R10 set wins", ovf_o, 1'b1);
    chk("R10 count after", count_o, 8'h01);

    // R11 count write beats reload
    wr(A_FLAGCLR, 8'h01);
    wr(A_RELOAD, 8'h40);
    wr(A_COUNT, 8'hFF);
    wr(A_CTRL, 8'h01);
    wr(A_COUNT, 8'h22);
    wr(A_CTRL, 8'h00);
    chk("R11 write wins", count_o, 8'h23);
    chk("R11 flag", ovf_o, 1'b1);
    chk("R11 reload kept", reload_o, 8'h40);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule